// File: doc/BRIEF.md
# MSI Vector Capture and Interrupt Controller

This block collects message-signalled interrupts for a PCIe root complex and turns them into one level interrupt toward the CPU. Software programs a 64-bit message target address, a per-vector enable word and a per-vector mask word through a 32-bit register port. When a write comes in on the inbound message port and its address equals the programmed target, the block reads the write's data as a vector number and latches that vector in a status word.

The CPU interrupt rises when a captured message leaves at least one unmasked status bit set. Software services vectors by writing the status word. That write flips every bit written as 1. The interrupt drops only when such a write leaves the whole status word at zero. Register reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle.

Top module: `msi_vec_capture`

## Requirements
- R1: The target address is a 64-bit register. The low word is at offset 0x820 and the high word at offset 0x824. A write to one half leaves the other half unchanged, and both halves read back what was written.
- R2: The enable, mask and status words read back at offsets 0x828, 0x82C and 0x830. Any other offset reads as zero.
- R3: An accepted message with data value N sets status bit N only when enable bit N is 1. An accepted message never changes any other status bit.
- R4: A message is accepted only when all of the following hold: the enable word is nonzero, all four byte enables are set (`msg_be` = 4'hF), the address equals the stored target exactly, and the data value is below 32. Otherwise the message has no effect on status or on the interrupt.
- R5: On the clock edge that takes an accepted message, `irq_out` becomes 1 if the resulting status has any bit set whose mask bit is 0. This holds even when the message's own vector bit was not enabled.
- R6: A captured vector whose mask bit is 1 does not raise `irq_out` by itself. Writing the mask word never changes `irq_out`.
- R7: A register write to the status word replaces status with status XOR the written value. Status changes only through such a write or through an accepted message.
- R8: `irq_out` falls only on a status write that leaves status equal to zero. A status write that leaves any bit set keeps the interrupt high.
- R9: After reset the target, enable, mask and status registers read zero and `irq_out` is 0.
- R10: When a status write and an accepted message occur in the same cycle, the XOR is applied first and the message's vector bit is ORed in afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| msg_valid | input | 1 | Inbound memory write present this cycle |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data (vector number) |
| msg_be | input | 4 | Inbound write byte enables |
| irq_out | output | 1 | Level interrupt toward the CPU |

## Verification
Messages are sent with vector numbers that are enabled, not enabled, masked and out of range. The bench also sends messages with a wrong address, with partial byte enables, and while the enable word is zero. Together these separate the capture gate from each acceptance condition. Status writes are chosen to clear one bit of two, to write zero, and to set a bit by toggling, which tells XOR apart from write-one-to-clear and from a plain store. Status writes that coincide with a message for the same vector, and with a message for a different vector, check the order in which the two updates are applied.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_TGT_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFS_TGT_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFS_ENA    = 12'h828;
  localparam logic [REG_AW-1:0] OFS_MSK    = 12'h82C;
  localparam logic [REG_AW-1:0] OFS_STS    = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TGT_LO,
    SEL_TGT_HI,
    SEL_ENA,
    SEL_MSK,
    SEL_STS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_TGT_LO: s = SEL_TGT_LO;
      OFS_TGT_HI: s = SEL_TGT_HI;
      OFS_ENA:    s = SEL_ENA;
      OFS_MSK:    s = SEL_MSK;
      OFS_STS:    s = SEL_STS;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
  import msi_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int TGT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sts_in,
  output logic [TGT_W-1:0]  tgt_q,
  output logic [DATA_W-1:0] ena_q,
  output logic [DATA_W-1:0] msk_q,
  output logic              sts_wr,
  output logic [DATA_W-1:0] sts_wval,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e sel;

  assign sel      = decode_ofs(addr);
  assign sts_wr   = wr_en && (sel == SEL_STS);
  assign sts_wval = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ena_q <= '0;
      msk_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_TGT_LO: tgt_q[DATA_W-1:0]     <= wdata;
        SEL_TGT_HI: tgt_q[TGT_W-1:DATA_W] <= wdata;
        SEL_ENA:    ena_q                 <= wdata;
        SEL_MSK:    msk_q                 <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_TGT_LO: rdata = tgt_q[DATA_W-1:0];
      SEL_TGT_HI: rdata = tgt_q[TGT_W-1:DATA_W];
      SEL_ENA:    rdata = ena_q;
      SEL_MSK:    rdata = msk_q;
      SEL_STS:    rdata = sts_in;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/msi_cap_detect.sv
module msi_cap_detect #(
  parameter int DATA_W = 32,
  localparam int TGT_W = 2 * DATA_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              msg_valid,
  input  logic [TGT_W-1:0]  msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic [BE_W-1:0]   msg_be,
  input  logic [TGT_W-1:0]  tgt,
  input  logic [DATA_W-1:0] ena,
  output logic              hit,
  output logic [DATA_W-1:0] vec
);

  function automatic logic accept(input logic v, input logic [BE_W-1:0] be,
                                  input logic addr_eq, input logic [DATA_W-1:0] en,
                                  input logic [DATA_W-1:0] d);
    return v && (&be) && addr_eq && (|en) && (d < DATA_W);
  endfunction

  logic addr_eq;

  assign addr_eq = (msg_addr == tgt);
  assign hit     = accept(msg_valid, msg_be, addr_eq, ena, msg_data);

  for (genvar i = 0; i < DATA_W; i++) begin : g_vec
    assign vec[i] = hit && ena[i] && (msg_data == DATA_W'(i));
  end

endmodule

// File: rtl/msi_cap_status.sv
module msi_cap_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] sts_wval,
  input  logic              hit,
  input  logic [DATA_W-1:0] vec,
  input  logic [DATA_W-1:0] msk,
  output logic [DATA_W-1:0] sts_q,
  output logic              irq_q
);

  function automatic logic [DATA_W-1:0] next_status(input logic [DATA_W-1:0] cur,
                                                    input logic wr,
                                                    input logic [DATA_W-1:0] wv,
                                                    input logic [DATA_W-1:0] set);
    logic [DATA_W-1:0] t;
    t = wr ? (cur ^ wv) : cur;
    return t | set;
  endfunction

  function automatic logic next_irq(input logic cur, input logic wr, input logic h,
                                    input logic [DATA_W-1:0] ns,
                                    input logic [DATA_W-1:0] m);
    logic r;
    r = cur;
    if (wr && (ns == '0)) r = 1'b0;
    if (h && ((ns & ~m) != '0)) r = 1'b1;
    return r;
  endfunction

  logic [DATA_W-1:0] sts_d;

  assign sts_d = next_status(sts_q, sts_wr, sts_wval, vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= next_irq(irq_q, sts_wr, hit, sts_d, msk);
    end
  end

endmodule

// File: rtl/msi_vec_capture.sv
module msi_vec_capture
  import msi_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int TGT_W = 2 * DATA_W,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              msg_valid,
  input  logic [TGT_W-1:0]  msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic [BE_W-1:0]   msg_be,
  output logic              irq_out
);

  logic [TGT_W-1:0]  tgt;
  logic [DATA_W-1:0] ena;
  logic [DATA_W-1:0] msk;
  logic [DATA_W-1:0] sts;
  logic              sts_wr;
  logic [DATA_W-1:0] sts_wval;
  logic              cap_hit;
  logic [DATA_W-1:0] cap_vec;

  msi_cap_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .sts_in   (sts),
    .tgt_q    (tgt),
    .ena_q    (ena),
    .msk_q    (msk),
    .sts_wr   (sts_wr),
    .sts_wval (sts_wval),
    .rdata    (reg_rdata)
  );

  msi_cap_detect #(.DATA_W(DATA_W)) u_det (
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .msg_be    (msg_be),
    .tgt       (tgt),
    .ena       (ena),
    .hit       (cap_hit),
    .vec       (cap_vec)
  );

  msi_cap_status #(.DATA_W(DATA_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .sts_wr   (sts_wr),
    .sts_wval (sts_wval),
    .hit      (cap_hit),
    .vec      (cap_vec),
    .msk      (msk),
    .sts_q    (sts),
    .irq_q    (irq_out)
  );

endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk
  import msi_cap_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int TGT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [TGT_W-1:0]  tgt,
  input logic [DATA_W-1:0] ena,
  input logic [DATA_W-1:0] sts,
  input logic              sts_wr,
  input logic              hit,
  input logic [DATA_W-1:0] vec,
  input logic              irq
);

  AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_TGT_HI) |=> $stable(tgt[DATA_W-1:0])); // R1

  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_TGT_LO) |=> $stable(tgt[TGT_W-1:DATA_W])); // R1

  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec)); // R3

  AST_VEC_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (vec & ~ena) == '0); // R3

  AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == '0) |-> !hit); // R4

  AST_IRQ_RISE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit)); // R5

  AST_STS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_wr && !hit) |=> $stable(sts)); // R7

  AST_IRQ_FALL_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(sts_wr) && sts == '0)); // R8

endmodule

bind msi_vec_capture msi_cap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .tgt       (tgt),
  .ena       (ena),
  .sts       (sts),
  .sts_wr    (sts_wr),
  .hit       (cap_hit),
  .vec       (cap_vec),
  .irq       (irq_out)
);

// File: tb/tb_msi_vec_capture.sv
`timescale 1ns/1ps
module tb_msi_vec_capture;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic [3:0]  msg_be = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  bit          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

  always #2 clk = ~clk;

  msi_vec_capture dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_be(msg_be), .irq_out(irq_out)
  );

  // monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_kind.size() > 0) begin
        bit k;
        logic [31:0] e, act;
        string t;
        k = q_kind.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        act = k ? {31'b0, irq_out} : reg_rdata;
        n_chk++;
        if (act !== e) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic step_end();
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
    msg_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    step_end();
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d; msg_be = be;
    step_end();
  endtask

  task automatic send_and_clear(input logic [31:0] wv, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 12'h830; reg_wdata = wv;
    msg_valid = 1'b1; msg_addr = TGT; msg_data = d; msg_be = 4'hF;
    step_end();
  endtask

  task automatic exp_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(tag);
    step_end();
  endtask

  task automatic exp_irq(input logic e, input string tag);
    @(negedge clk);
    q_kind.push_back(1'b1); q_exp.push_back({31'b0, e}); q_tag.push_back(tag);
    step_end();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    exp_rd(12'h820, 32'h0, "R9 tgt lo");
    exp_rd(12'h824, 32'h0, "R9 tgt hi");
    exp_rd(12'h828, 32'h0, "R9 enable");
    exp_rd(12'h82C, 32'h0, "R9 mask");
    exp_rd(12'h830, 32'h0, "R9 status");
    exp_irq(1'b0, "R9 irq");

    // R1 target halves
    wr_reg(12'h820, 32'hFEE0_0040);
    wr_reg(12'h824, 32'h0000_0001);
    exp_rd(12'h820, 32'hFEE0_0040, "R1 lo");
    wr_reg(12'h820, 32'hFEE0_1000);
    exp_rd(12'h824, 32'h0000_0001, "R1 hi kept");
    exp_rd(12'h820, 32'hFEE0_1000, "R1 lo new");

    // R2 unmapped
    exp_rd(12'h700, 32'h0, "R2 unmapped");

    // R4 enable word zero
    send(TGT, 32'd3, 4'hF);
    exp_rd(12'h830, 32'h0, "R4 disabled status");
    exp_irq(1'b0, "R4 disabled irq");

    wr_reg(12'h828, 32'h0000_00F0);
    exp_rd(12'h828, 32'h0000_00F0, "R2 enable");

    // R3 vector not enabled
    send(TGT, 32'd2, 4'hF);
    exp_rd(12'h830, 32'h0, "R3 not enabled");
    exp_irq(1'b0, "R3 not enabled irq");

    // R3/R5 enabled vector
    send(TGT, 32'd5, 4'hF);
    exp_rd(12'h830, 32'h0000_0020, "R3 capture");
    exp_irq(1'b1, "R5 irq rise");

    // R4 rejections
    send(TGT + 64'd4, 32'd6, 4'hF);
    send(TGT, 32'd7, 4'h7);
    send(TGT, 32'd40, 4'hF);
    exp_rd(12'h830, 32'h0000_0020, "R4 rejected messages");

    // R7/R8 clear
    wr_reg(12'h830, 32'h0000_0020);
    exp_rd(12'h830, 32'h0, "R7 xor clear");
    exp_irq(1'b0, "R8 irq fall");

    // R6 masked capture
    wr_reg(12'h82C, 32'h0000_0040);
    exp_rd(12'h82C, 32'h0000_0040, "R2 mask");
    send(TGT, 32'd6, 4'hF);
    exp_rd(12'h830, 32'h0000_0040, "R6 masked status");
    exp_irq(1'b0, "R6 masked irq");
    wr_reg(12'h82C, 32'h0);
    exp_irq(1'b0, "R6 mask write no irq");

    // R5 accepted message with non-enabled vector raises on pending
    send(TGT, 32'd2, 4'hF);
    exp_irq(1'b1, "R5 pending raise");
    wr_reg(12'h830, 32'h0000_0040);
    exp_irq(1'b0, "R8 clear pending");

    // R8 partial clear, R7 xor set
    send(TGT, 32'd4, 4'hF);
    send(TGT, 32'd7, 4'hF);
    exp_rd(12'h830, 32'h0000_0090, "R3 two vectors");
    wr_reg(12'h830, 32'h0000_0010);
    exp_rd(12'h830, 32'h0000_0080, "R7 partial");
    exp_irq(1'b1, "R8 partial keeps irq");
    wr_reg(12'h830, 32'h0);
    exp_irq(1'b1, "R8 zero write keeps irq");
    wr_reg(12'h830, 32'h0000_0081);
    exp_rd(12'h830, 32'h0000_0001, "R7 toggle sets");
    wr_reg(12'h830, 32'h0000_0001);
    exp_irq(1'b0, "R8 final clear");

    // R10 same-cycle
    send(TGT, 32'd4, 4'hF);
    send_and_clear(32'h0000_0010, 32'd4);
    exp_rd(12'h830, 32'h0000_0010, "R10 same vector");
    exp_irq(1'b1, "R10 irq held");
    send_and_clear(32'h0000_0010, 32'd5);
    exp_rd(12'h830, 32'h0000_0020, "R10 other vector");
    wr_reg(12'h830, 32'h0000_0020);
    exp_irq(1'b0, "R10 cleared");

    // R6 all masked
    wr_reg(12'h82C, 32'hFFFF_FFFF);
    send(TGT, 32'd5, 4'hF);
    exp_rd(12'h830, 32'h0000_0020, "R6 all masked status");
    exp_irq(1'b0, "R6 all masked irq");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule